// File: doc/BRIEF.md
# Accumulator CPU with Micro-Sequenced Control

This block is a small 8-bit processor built around one accumulator and sixteen bytes of internal memory, which hold both code and data. A 4-bit program counter steps through memory. A T-state counter sequences fetch and execute micro-operations over a shared internal path. Sixteen opcodes cover memory loads and stores, immediate loads and arithmetic, add/subtract/XOR/AND, flag-conditional jumps, a blocking input instruction, an output latch and halt.

There are two modes, chosen by `run_mode`. With `run_mode` low (load mode), a host writes memory one byte at a time through an address, a data byte and a write strobe, and sequencing is frozen. With `run_mode` high (program mode), a pulse on `go` starts execution from address 0. The output byte, the program counter, a halted flag and an input-request flag are visible at the ports. The input instruction raises a request and waits until the host pulses an acknowledge with the byte on `data_in`. That byte is stored in memory at the instruction's address field.

Top module: `acc8_cpu`

## Requirements
- R1: While `rst_n` is low, the sequencer returns to idle, and the program counter, accumulator, flags, output latch and halt state clear. After reset, `pc_out` = 0, `halted` = 0, `in_req` = 0 and `out_byte` = 0.
- R2: With `run_mode` = 0, a one-cycle `ram_wr` stores `data_in` at memory location `ram_addr`. With `run_mode` = 1, `ram_wr` is ignored.
- R3: Nothing is sequenced until `go` is sampled high while `run_mode` = 1 and the CPU is idle and not halted. Execution then begins with the fetch of address 0.
- R4: An instruction byte carries the opcode in bits [7:4] and an address or immediate in bits [3:0]. Every instruction other than INP takes exactly 6 clock cycles. Fetch uses the first three, and the program counter increments at the end of the third.
- R5: LDA (0001) loads memory[addr] into the accumulator. STA (0100) stores the accumulator at memory[addr]. ADD (0010), SUB (0011), XRA (1011) and ANA (1100) combine the accumulator with memory[addr] and put the result in the accumulator.
- R6: LDI (0101) loads the zero-extended 4-bit immediate. ADI (1001) adds it to the accumulator and SUI (1010) subtracts it from the accumulator.
- R7: Only ADD, SUB, XRA, ANA, ADI and SUI change the flags. Zero is set when the 8-bit result is 0. Carry is the carry out of an add, or 1 when a subtract needs no borrow (accumulator >= operand). XOR and AND clear carry.
- R8: JMP (0110) always loads the program counter with the address field. JC (0111) does so only when carry = 1, and JZ (1000) only when zero = 1. Otherwise execution continues with the next address.
- R9: NOP (0000) changes no register other than the program counter advance.
- R10: INP (1101) raises `in_req` and stalls until `in_ack` is sampled high. It then writes `data_in` to memory[addr] and finishes one cycle later than the other instructions, taking 7 cycles when acknowledged at once.
- R11: OUT (1110) copies the accumulator into the output latch. `out_byte` shows the latch while `run_mode` = 1 and shows 0 while `run_mode` = 0.
- R12: HLT (1111) stops sequencing and raises `halted`. `halted`, `pc_out` and the output latch then hold until reset, and `go` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 1 = program mode, 0 = load mode |
| go | input | 1 | Start pulse, program mode |
| in_ack | input | 1 | Acknowledge for a pending input request |
| ram_wr | input | 1 | Memory write strobe, load mode |
| ram_addr | input | 4 | Memory address for manual writes |
| data_in | input | 8 | Byte for manual writes or input instruction |
| out_byte | output | 8 | Output latch (0 in load mode) |
| pc_out | output | 4 | Current program counter |
| halted | output | 1 | CPU has executed HLT |
| in_req | output | 1 | Input instruction waiting for data |

## Verification
The bench checks the flag corner cases. An add that wraps past 0xFF must set carry, and a subtract with a borrow must clear it, so a design with inverted borrow sense takes the wrong JC branch. A design that lets a load or XOR leave stale flags, or lets them alter flags, steers a following JC or JZ onto a path that outputs a different byte. The input stall is held for many cycles without an acknowledge, which exposes a sequencer that runs on or drops the request. Cycle counts on a NOP stream expose a wrong fetch length. A write strobe given in program mode, and a missing start pulse, expose designs that write memory or start running when they should not.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

    localparam int OP_W       = 4;
    localparam int T_W        = 3;
    localparam int T_FETCH_A  = 0;
    localparam int T_FETCH_I  = 1;
    localparam int T_PC_INC   = 2;
    localparam int T_EXEC1    = 3;
    localparam int T_EXEC2    = 4;
    localparam int T_EXEC3    = 5;
    localparam int T_EXTRA    = 6;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_STA = 4'h4,
        OP_LDI = 4'h5,
        OP_JMP = 4'h6,
        OP_JC  = 4'h7,
        OP_JZ  = 4'h8,
        OP_ADI = 4'h9,
        OP_SUI = 4'hA,
        OP_XRA = 4'hB,
        OP_ANA = 4'hC,
        OP_INP = 4'hD,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } op_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_XOR = 2'd2,
        FN_AND = 2'd3
    } alu_fn_e;

endpackage

// File: rtl/acc8_alu.sv
module acc8_alu
    import acc8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         c,
    output logic         z
);

    logic [W:0] wide;

    always_comb begin
        wide = '0;
        y    = '0;
        c    = 1'b0;
        unique case (fn)
            FN_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                y    = wide[W-1:0];
                c    = wide[W];
            end
            FN_SUB: begin
                y = a - b;
                c = (a >= b);
            end
            FN_XOR: y = a ^ b;
            FN_AND: y = a & b;
            default: y = '0;
        endcase
        z = (y == '0);
    end

endmodule

// File: rtl/acc8_ram.sv
module acc8_ram #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/acc8_cpu.sv
module acc8_cpu
    import acc8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_mode,
    input  logic                      go,
    input  logic                      in_ack,
    input  logic                      ram_wr,
    input  logic [DATA_W-OP_W-1:0]    ram_addr,
    input  logic [DATA_W-1:0]         data_in,
    output logic [DATA_W-1:0]         out_byte,
    output logic [DATA_W-OP_W-1:0]    pc_out,
    output logic                      halted,
    output logic                      in_req
);

    localparam int ADDR_W = DATA_W - OP_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] breg;
        logic [DATA_W-1:0] outr;
        logic              zf;
        logic              cf;
        logic              run;
        logic              halt;
        logic [T_W-1:0]    t;
    } cpu_st_t;

    cpu_st_t st_d, st_q;

    logic [T_W-1:0]    t_cur;
    op_e               op_cur;
    logic [ADDR_W-1:0] imm;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] out_reg;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    alu_fn_e           alu_fn;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;
    logic              alu_z;

    assign t_cur   = st_q.t;
    assign op_cur  = op_e'(st_q.ir[DATA_W-1 -: OP_W]);
    assign imm     = st_q.ir[ADDR_W-1:0];
    assign imm_ext = {{(DATA_W-ADDR_W){1'b0}}, imm};
    assign out_reg = st_q.outr;

    acc8_ram #(
        .W  (DATA_W),
        .AW (ADDR_W)
    ) ram_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (st_q.mar),
        .rdata (mem_rdata)
    );

    always_comb begin
        unique case (op_cur)
            OP_SUB, OP_SUI: alu_fn = FN_SUB;
            OP_XRA:         alu_fn = FN_XOR;
            OP_ANA:         alu_fn = FN_AND;
            default:        alu_fn = FN_ADD;
        endcase
        alu_b = (t_cur == T_W'(T_EXEC1)) ? imm_ext : st_q.breg;
    end

    acc8_alu #(
        .W (DATA_W)
    ) alu_i (
        .a  (st_q.acc),
        .b  (alu_b),
        .fn (alu_fn),
        .y  (alu_y),
        .c  (alu_c),
        .z  (alu_z)
    );

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        mem_waddr = st_q.mar;
        mem_wdata = st_q.acc;

        if (!run_mode) begin
            if (ram_wr) begin
                mem_we    = 1'b1;
                mem_waddr = ram_addr;
                mem_wdata = data_in;
            end
        end else if (!st_q.run) begin
            if (go && !st_q.halt) begin
                st_d.run = 1'b1;
                st_d.t   = '0;
            end
        end else begin
            st_d.t = t_cur + 1'b1;
            unique case (t_cur)
                T_W'(T_FETCH_A): st_d.mar = st_q.pc;
                T_W'(T_FETCH_I): st_d.ir  = mem_rdata;
                T_W'(T_PC_INC):  st_d.pc  = st_q.pc + 1'b1;
                T_W'(T_EXEC1): begin
                    unique case (op_cur)
                        OP_LDA, OP_ADD, OP_SUB, OP_STA,
                        OP_XRA, OP_ANA, OP_INP: st_d.mar = imm;
                        OP_LDI: st_d.acc = imm_ext;
                        OP_JMP: st_d.pc  = imm;
                        OP_JC:  if (st_q.cf) st_d.pc = imm;
                        OP_JZ:  if (st_q.zf) st_d.pc = imm;
                        OP_ADI, OP_SUI: begin
                            st_d.acc = alu_y;
                            st_d.cf  = alu_c;
                            st_d.zf  = alu_z;
                        end
                        OP_OUT: st_d.outr = st_q.acc;
                        OP_HLT: begin
                            st_d.halt = 1'b1;
                            st_d.run  = 1'b0;
                            st_d.t    = '0;
                        end
                        default: ;
                    endcase
                end
                T_W'(T_EXEC2): begin
                    unique case (op_cur)
                        OP_LDA: st_d.acc = mem_rdata;
                        OP_STA: mem_we   = 1'b1;
                        OP_ADD, OP_SUB, OP_XRA, OP_ANA: st_d.breg = mem_rdata;
                        OP_INP: begin
                            if (in_ack) begin
                                mem_we    = 1'b1;
                                mem_wdata = data_in;
                            end else begin
                                st_d.t = t_cur;
                            end
                        end
                        default: ;
                    endcase
                end
                T_W'(T_EXEC3): begin
                    unique case (op_cur)
                        OP_ADD, OP_SUB, OP_XRA, OP_ANA: begin
                            st_d.acc = alu_y;
                            st_d.cf  = alu_c;
                            st_d.zf  = alu_z;
                        end
                        default: ;
                    endcase
                    st_d.t = (op_cur == OP_INP) ? T_W'(T_EXTRA) : '0;
                end
                default: st_d.t = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_byte = run_mode ? out_reg : '0;
    assign pc_out   = st_q.pc;
    assign halted   = st_q.halt;
    assign in_req   = st_q.run && run_mode && (op_cur == OP_INP)
                      && (t_cur == T_W'(T_EXEC2));

endmodule

// File: rtl/acc8_cpu_chk.sv
module acc8_cpu_chk #(
    parameter int DW = 8,
    parameter int AW = 4,
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ack,
    input logic          in_req,
    input logic          halted,
    input logic [AW-1:0] pc_out,
    input logic [TW-1:0] t_q,
    input logic [3:0]    op_q,
    input logic [DW-1:0] outr_q
);

    // R12: halt persists until reset
    a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R12: program counter frozen once halted
    a_r12_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_out));

    // R12: output latch keeps its value after halt
    a_r12_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(outr_q));

    // R10: an unanswered request stays up
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_ack) |=> in_req);

    // R10: program counter does not move while waiting for input
    a_r10_pc_still: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_ack) |=> $stable(pc_out));

    // R10: no request from a halted CPU
    a_r10_req_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
        in_req |-> !halted);

    // R4: the seventh state exists only for the input instruction
    a_r4_extra_state: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q == TW'(6)) |-> (op_q == 4'hD));

    // R4: the state counter never passes the seventh state
    a_r4_t_range: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= TW'(6));

endmodule

bind acc8_cpu acc8_cpu_chk #(
    .DW (DATA_W),
    .AW (ADDR_W),
    .TW (acc8_pkg::T_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_ack (in_ack),
    .in_req (in_req),
    .halted (halted),
    .pc_out (pc_out),
    .t_q    (t_cur),
    .op_q   (op_cur),
    .outr_q (out_reg)
);

// File: tb/acc8_cpu_tb.sv
`timescale 1ns/1ps
module acc8_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_mode = 1'b0;
    logic       go = 1'b0;
    logic       in_ack = 1'b0;
    logic       ram_wr = 1'b0;
    logic [3:0] ram_addr = '0;
    logic [7:0] data_in = '0;
    logic [7:0] out_byte;
    logic [3:0] pc_out;
    logic       halted;
    logic       in_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc8_cpu dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_mode (run_mode),
        .go       (go),
        .in_ack   (in_ack),
        .ram_wr   (ram_wr),
        .ram_addr (ram_addr),
        .data_in  (data_in),
        .out_byte (out_byte),
        .pc_out   (pc_out),
        .halted   (halted),
        .in_req   (in_req)
    );

    // program bytes 0..7, memory E, memory F, expected output
    localparam logic [87:0] VEC [16] = '{
        88'h1E_2F_E0_F0_F0_F0_F0_F0_70_25_95,
        88'h1E_3F_E0_F0_F0_F0_F0_F0_10_30_E0,
        88'h1E_BF_E0_F0_F0_F0_F0_F0_F0_3C_CC,
        88'h1E_CF_E0_F0_F0_F0_F0_F0_F0_3C_30,
        88'h57_99_E0_F0_F0_F0_F0_F0_00_00_10,
        88'h53_A5_E0_F0_F0_F0_F0_F0_00_00_FE,
        88'h1E_2F_75_F0_F0_E0_F0_F0_F0_20_10,
        88'h1E_2F_75_E0_F0_5A_E0_F0_01_02_03,
        88'h1E_3F_85_E0_F0_5A_E0_F0_44_44_0A,
        88'h1E_3F_85_E0_F0_5A_E0_F0_45_44_01,
        88'h56_64_E0_F0_91_E0_F0_F0_00_00_07,
        88'h1E_4D_5F_1D_E0_F0_F0_F0_5A_00_5A,
        88'h1E_3F_75_E0_F0_50_E0_F0_10_30_E0,
        88'h00_00_57_E0_F0_F0_F0_F0_00_00_07,
        88'h91_1E_85_E0_F0_5C_E0_F0_00_00_00,
        88'h1E_2F_BF_76_E0_F0_5C_E0_F0_20_30
    };

    function automatic string vtag(int i);
        case (i)
            0, 1, 2, 3: return "R5 memory ALU";
            4, 5:       return "R6 immediate";
            6, 7:       return "R8 JC carry";
            8, 9:       return "R8 JZ zero";
            10:         return "R8 JMP";
            11:         return "R5 STA/LDA";
            12:         return "R7 borrow clears carry";
            13:         return "R9 NOP";
            14:         return "R7 LDA keeps flags";
            default:    return "R7 XOR clears carry";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; go = 1'b0; ram_wr = 1'b0; in_ack = 1'b0; run_mode = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_byte(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        run_mode = 1'b0; ram_addr = a; data_in = d; ram_wr = 1'b1;
        @(negedge clk);
        ram_wr = 1'b0;
    endtask

    task automatic pulse_go();
        @(negedge clk);
        run_mode = 1'b1; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_halt(input int limit);
        for (int k = 0; k < limit && !halted; k++) @(negedge clk);
    endtask

    task automatic wait_req(input int limit);
        for (int k = 0; k < limit && !in_req; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        run_mode = 1'b1;
        @(negedge clk);
        chk(pc_out == 4'h0, "R1 pc after reset", pc_out, 0);
        chk(halted == 1'b0, "R1 halted after reset", halted, 0);
        chk(in_req == 1'b0, "R1 in_req after reset", in_req, 0);
        chk(out_byte == 8'h00, "R1 output after reset", out_byte, 0);

        // table of short programs
        for (int i = 0; i < 16; i++) begin
            do_reset();
            for (int a = 0; a < 16; a++) begin
                logic [7:0] b;
                if (a < 8)       b = VEC[i][87-8*a -: 8];
                else if (a == 14) b = VEC[i][23:16];
                else if (a == 15) b = VEC[i][15:8];
                else             b = 8'hF0;
                load_byte(a[3:0], b);
            end
            pulse_go();
            wait_halt(300);
            chk(halted == 1'b1, {vtag(i), " halts"}, halted, 1);
            chk(out_byte == VEC[i][7:0], vtag(i), out_byte, VEC[i][7:0]);
        end

        // R4: six cycles per instruction on a NOP stream
        do_reset();
        for (int a = 0; a < 16; a++) load_byte(a[3:0], 8'h00);
        pulse_go();
        repeat (3) @(negedge clk);
        chk(pc_out == 4'h1, "R4 pc after fetch", pc_out, 1);
        repeat (5) @(negedge clk);
        chk(pc_out == 4'h1, "R4 pc before second fetch ends", pc_out, 1);
        @(negedge clk);
        chk(pc_out == 4'h2, "R4 pc after two instructions", pc_out, 2);

        // R2 and R3: write ignored in program mode; no start without go
        do_reset();
        load_byte(4'h0, 8'h5A);
        load_byte(4'h1, 8'hE0);
        load_byte(4'h2, 8'hF0);
        @(negedge clk);
        run_mode = 1'b1; ram_addr = 4'h0; data_in = 8'hF0; ram_wr = 1'b1;
        @(negedge clk);
        ram_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk(pc_out == 4'h0, "R3 no run before go", pc_out, 0);
        chk(halted == 1'b0, "R3 not halted before go", halted, 0);
        pulse_go();
        wait_halt(100);
        chk(out_byte == 8'h0A, "R2 program-mode write ignored", out_byte, 8'h0A);

        // R10: acceptance program with input handshake
        do_reset();
        load_byte(4'h0, 8'hDE);
        load_byte(4'h1, 8'hDF);
        load_byte(4'h2, 8'h1E);
        load_byte(4'h3, 8'h2F);
        load_byte(4'h4, 8'hE0);
        for (int a = 5; a < 14; a++) load_byte(a[3:0], 8'hF0);
        pulse_go();
        repeat (4) @(negedge clk);
        chk(in_req == 1'b1, "R10 request raised in fourth cycle", in_req, 1);
        repeat (10) @(negedge clk);
        chk(in_req == 1'b1, "R10 request held while waiting", in_req, 1);
        chk(pc_out == 4'h1, "R10 pc stalled", pc_out, 1);
        data_in = 8'h05; in_ack = 1'b1;
        @(negedge clk);
        in_ack = 1'b0;
        chk(in_req == 1'b0, "R10 request drops after ack", in_req, 0);
        // remaining two cycles of INP plus three fetch cycles
        repeat (5) @(negedge clk);
        chk(pc_out == 4'h2, "R10 seven-cycle INP then fetch", pc_out, 2);
        wait_req(50);
        data_in = 8'h03; in_ack = 1'b1;
        @(negedge clk);
        in_ack = 1'b0;
        wait_halt(200);
        chk(halted == 1'b1, "R12 halted raised", halted, 1);
        chk(out_byte == 8'h08, "R11 output of 5+3", out_byte, 8'h08);
        chk(pc_out == 4'h6, "R12 pc after HLT", pc_out, 6);
        pulse_go();
        repeat (10) @(negedge clk);
        chk(out_byte == 8'h08, "R12 output held after halt", out_byte, 8'h08);
        chk(pc_out == 4'h6, "R12 go ignored when halted", pc_out, 6);
        run_mode = 1'b0;
        @(negedge clk);
        chk(out_byte == 8'h00, "R11 zero in load mode", out_byte, 0);
        run_mode = 1'b1;
        @(negedge clk);
        chk(out_byte == 8'h08, "R11 latch back in program mode", out_byte, 8'h08);

        // R1: reset after halt
        do_reset();
        run_mode = 1'b1;
        @(negedge clk);
        chk(halted == 1'b0, "R1 reset clears halt", halted, 0);
        chk(out_byte == 8'h00, "R1 reset clears output", out_byte, 0);
        chk(pc_out == 4'h0, "R1 reset clears pc", pc_out, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule